// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block controls 8-bit successive-approximation conversions for a small microcontroller. It sits between the bus-side register fields and the conversion datapath. A write to the control fields selects a channel and picks single or continuous operation. The block then waits for the next enabled ADC clock edge and starts a conversion. That conversion runs a fixed fourteen ADC clocks. During the run the block presents a trial code to an external comparator and builds the result one bit at a time. At the end it latches the result into the data register and raises the conversion-complete flag.

The bus and ADC clocks share one clock. The ADC clock appears as the enable strobe `adc_ce`. The sequencer is built around three states:

- `ST_IDLE` means no conversion is pending.
- `ST_ARMED` means a start has been requested and the block is waiting for the first enabled edge.
- `ST_CONV` means a conversion is running, with a cycle counter.

It moves between those states through five transitions:

- T_WRITE_START: any state to `ST_ARMED`, on a control write that names a real channel.
- T_WRITE_OFF: any state to `ST_IDLE`, on a control write of the off code.
- T_LAUNCH: `ST_ARMED` to `ST_CONV`, on the first enabled edge.
- T_DONE_SINGLE: `ST_CONV` to `ST_IDLE`, at the end of a single conversion.
- T_DONE_CONT: `ST_CONV` back to `ST_CONV` with the counter cleared, at the end of a conversion in continuous mode.

The block also owns the port pin of the selected channel. It removes that pin's output drive and masks its port read.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion ends exactly fourteen enabled ADC edges after its start edge. On that edge the result is written to `adc_data` and `coco` is raised.
- R2: A conversion starts on the first enabled edge strictly after the clock edge that takes `ctl_wr`. The write-to-flag latency is therefore fifteen enabled edges.
- R3: The comparator input `cmp_in` reads 1 when the analog input is at or above `trial_code`. With that rule the result equals the input level for inputs from 0 to 255. An input above 255 gives 0xFF and an input below 0 gives 0x00.
- R4: With `ctl_wr_cont` = 1, conversions of the selected channel run back to back, one result every fourteen enabled edges, until a write clears the mode.
- R5: `coco` is set at the end of every conversion. If a data read arrives on the same edge as the end of a conversion, the set wins.
- R6: In single mode `busy` falls on the edge that ends the conversion. The block then stays idle and `adc_data` holds until the next control write.
- R7: Any control write clears `coco`. A data read (`data_rd`) also clears `coco`.
- R8: Each new result overwrites `adc_data` whether or not the previous one was read. `adc_data` changes at no other time.
- R9: A control write during a conversion aborts it. A new conversion on the newly written channel then starts on the next enabled edge, with the full fifteen-edge write-to-flag latency and no result from the aborted run.
- R10: The channel code of all ones (7 with the default 3-bit field) powers the converter off. No conversion starts, `busy` stays 0, and no pin is overridden.
- R11: For the selected pin, `pin_oe` is 0. Its `port_rd` bit returns `port_latch` when `port_dir` is 1 and 0 when it is 0. Every other pin has `pin_oe` = `port_dir`, and its read returns `port_latch` if `port_dir` = 1, else `pin_in`.
- R12: After reset `coco` = 0, `adc_data` = 0, `busy` = 0, `cont_mode` = 0 and `chan_sel` holds the off code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bus/ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_ce | input | 1 | ADC clock enable strobe |
| ctl_wr | input | 1 | Write strobe for the control fields |
| ctl_wr_chan | input | CH_W | Channel written by the control write |
| ctl_wr_cont | input | 1 | Continuous-mode bit written by the control write |
| data_rd | input | 1 | Read strobe of the data register |
| cmp_in | input | 1 | Comparator result: input at or above trial code |
| pin_in | input | 2**CH_W-1 | Levels sensed on the port pins |
| port_dir | input | 2**CH_W-1 | Port direction bits, 1 = output |
| port_latch | input | 2**CH_W-1 | Port data latch |
| chan_sel | output | CH_W | Selected channel |
| cont_mode | output | 1 | Continuous-mode bit |
| coco | output | 1 | Conversion-complete flag |
| adc_data | output | RES_W | Data register |
| busy | output | 1 | High while a start is pending or a conversion runs |
| trial_code | output | RES_W | Trial code presented to the comparator |
| port_rd | output | 2**CH_W-1 | Port read value after ADC masking |
| pin_oe | output | 2**CH_W-1 | Per-pin output enable |
| pin_out | output | 2**CH_W-1 | Per-pin drive value |

## Verification
Single conversions are run from a vector table. The table sweeps the input across zero, full scale, mid-scale and odd codes, and also drives levels beyond both supplies, which separates a correct clamp from a result that wraps around. Each vector also measures the write-to-flag distance in enabled edges, which exposes an off-by-one start or end. A continuous run measures the result spacing, then deliberately skips a read to confirm the overwrite. Directed cases then cover:

- an abort by rewriting a different channel mid-conversion, where the two channels carry distinct inputs so the source of the result is visible;
- the off code;
- pin masking, with distinct direction and latch patterns on owned and free pins.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    localparam int DEF_CH_W     = 3;
    localparam int DEF_RES_W    = 8;
    localparam int DEF_CONV_CYC = 14;

endpackage

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYC = DEF_CONV_CYC,
    parameter int CNT_W    = $clog2(CONV_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             wr_ctl,
    input  logic             wr_off,
    input  logic             cont_mode,
    output seq_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             start_o,
    output logic             step_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

    seq_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (wr_ctl) begin
            state_d = wr_off ? ST_IDLE : ST_ARMED;   // T_WRITE_OFF / T_WRITE_START
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_ARMED: begin
                    if (ce) begin                    // T_LAUNCH
                        state_d = ST_CONV;
                        cnt_d   = '0;
                    end
                end
                ST_CONV: begin
                    if (ce) begin
                        if (cnt_q == LAST) begin     // T_DONE_CONT / T_DONE_SINGLE
                            state_d = cont_mode ? ST_CONV : ST_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        start_o = 1'b0;
        step_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_o = 1'b0;
            end
            ST_ARMED: begin
                start_o = ce & ~wr_ctl;
            end
            ST_CONV: begin
                step_o  = ce & ~wr_ctl;
                done_o  = ce & ~wr_ctl & (cnt_q == LAST);
                start_o = ce & ~wr_ctl & (cnt_q == LAST) & cont_mode;
            end
            default: begin
                start_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_sar_engine.sv
`timescale 1ns/1ps
module adc_sar_engine #(
    parameter int RES_W = adc_seq_pkg::DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);

    localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] msk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            msk_q <= '0;
        end else if (start) begin
            acc_q <= '0;
            msk_q <= MSB;
        end else if (step && (msk_q != '0)) begin
            if (cmp_in) begin
                acc_q <= acc_q | msk_q;
            end
            msk_q <= msk_q >> 1;
        end
    end

    assign trial  = acc_q | msk_q;
    assign result = acc_q;

endmodule

// File: rtl/adc_pin_mux.sv
`timescale 1ns/1ps
module adc_pin_mux #(
    parameter int CH_W = adc_seq_pkg::DEF_CH_W,
    parameter int NPIN = (1 << CH_W) - 1
) (
    input  logic [CH_W-1:0] chan,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] port_dir,
    input  logic [NPIN-1:0] port_latch,
    output logic [NPIN-1:0] port_rd,
    output logic [NPIN-1:0] pin_oe
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic owned;
        assign owned = (chan == CH_W'(i));
        always_comb begin
            pin_oe[i] = port_dir[i] & ~owned;
            if (port_dir[i]) begin
                port_rd[i] = port_latch[i];
            end else begin
                port_rd[i] = owned ? 1'b0 : pin_in[i];
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W     = DEF_CH_W,
    parameter int RES_W    = DEF_RES_W,
    parameter int CONV_CYC = DEF_CONV_CYC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adc_ce,
    input  logic                     ctl_wr,
    input  logic [CH_W-1:0]          ctl_wr_chan,
    input  logic                     ctl_wr_cont,
    input  logic                     data_rd,
    input  logic                     cmp_in,
    input  logic [(1<<CH_W)-2:0]     pin_in,
    input  logic [(1<<CH_W)-2:0]     port_dir,
    input  logic [(1<<CH_W)-2:0]     port_latch,
    output logic [CH_W-1:0]          chan_sel,
    output logic                     cont_mode,
    output logic                     coco,
    output logic [RES_W-1:0]         adc_data,
    output logic                     busy,
    output logic [RES_W-1:0]         trial_code,
    output logic [(1<<CH_W)-2:0]     port_rd,
    output logic [(1<<CH_W)-2:0]     pin_oe,
    output logic [(1<<CH_W)-2:0]     pin_out
);

    localparam int              NPIN     = (1 << CH_W) - 1;
    localparam int              CNT_W    = $clog2(CONV_CYC);
    localparam logic [CH_W-1:0] OFF_CODE = '1;

    seq_state_e       seq_state;
    logic [CNT_W-1:0] seq_cnt;
    logic             conv_start;
    logic             conv_step;
    logic             conv_done;
    logic [RES_W-1:0] sar_result;
    logic             wr_off;

    assign wr_off = (ctl_wr_chan == OFF_CODE);

    adc_seq_fsm #(
        .CONV_CYC (CONV_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (adc_ce),
        .wr_ctl    (ctl_wr),
        .wr_off    (wr_off),
        .cont_mode (cont_mode),
        .state_q   (seq_state),
        .cnt_q     (seq_cnt),
        .start_o   (conv_start),
        .step_o    (conv_step),
        .done_o    (conv_done)
    );

    adc_sar_engine #(
        .RES_W (RES_W)
    ) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .step   (conv_step),
        .cmp_in (cmp_in),
        .trial  (trial_code),
        .result (sar_result)
    );

    adc_pin_mux #(
        .CH_W (CH_W),
        .NPIN (NPIN)
    ) u_pins (
        .chan       (chan_sel),
        .pin_in     (pin_in),
        .port_dir   (port_dir),
        .port_latch (port_latch),
        .port_rd    (port_rd),
        .pin_oe     (pin_oe)
    );

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_sel  <= OFF_CODE;
            cont_mode <= 1'b0;
        end else if (ctl_wr) begin
            chan_sel  <= ctl_wr_chan;
            cont_mode <= ctl_wr_cont;
        end
    end

    // complete flag: write clears, completion sets, read clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coco <= 1'b0;
        end else if (ctl_wr) begin
            coco <= 1'b0;
        end else if (conv_done) begin
            coco <= 1'b1;
        end else if (data_rd) begin
            coco <= 1'b0;
        end
    end

    // data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_data <= '0;
        end else if (conv_done) begin
            adc_data <= sar_result;
        end
    end

    assign busy    = (seq_state != ST_IDLE);
    assign pin_out = port_latch;

endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int CH_W     = DEF_CH_W,
    parameter int RES_W    = DEF_RES_W,
    parameter int CONV_CYC = DEF_CONV_CYC,
    parameter int CNT_W    = $clog2(CONV_CYC),
    parameter int NPIN     = (1 << CH_W) - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_ce,
    input logic             ctl_wr,
    input logic [CH_W-1:0]  ctl_wr_chan,
    input logic             data_rd,
    input logic [CH_W-1:0]  chan_sel,
    input logic             cont_mode,
    input logic             coco,
    input logic [RES_W-1:0] adc_data,
    input logic             busy,
    input logic [NPIN-1:0]  pin_oe,
    input seq_state_e       seq_state,
    input logic [CNT_W-1:0] seq_cnt,
    input logic             conv_done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CH_W-1:0]  OFF  = '1;

    p_cnt_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cnt <= LAST);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_ARMED && adc_ce && !ctl_wr) |=> (seq_state == ST_CONV && seq_cnt == '0));

    p_cont_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cont_mode) |=> (seq_state == ST_CONV && seq_cnt == '0));

    p_coco_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> coco);

    p_single_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cont_mode) |=> !busy);

    p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !coco);

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !conv_done && !ctl_wr) |=> !coco);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(adc_data));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wr_chan != OFF) |=> (seq_state == ST_ARMED && chan_sel == $past(ctl_wr_chan)));

    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel == OFF) |-> !busy);

    p_pin_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != OFF) |-> !pin_oe[chan_sel]);

endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .CH_W     (CH_W),
    .RES_W    (RES_W),
    .CONV_CYC (CONV_CYC),
    .CNT_W    (CNT_W),
    .NPIN     (NPIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_ce      (adc_ce),
    .ctl_wr      (ctl_wr),
    .ctl_wr_chan (ctl_wr_chan),
    .data_rd     (data_rd),
    .chan_sel    (chan_sel),
    .cont_mode   (cont_mode),
    .coco        (coco),
    .adc_data    (adc_data),
    .busy        (busy),
    .pin_oe      (pin_oe),
    .seq_state   (seq_state),
    .seq_cnt     (seq_cnt),
    .conv_done   (conv_done)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    localparam int CH_W  = 3;
    localparam int RES_W = 8;
    localparam int NPIN  = (1 << CH_W) - 1;
    localparam int LAT   = 15;   // write to flag, in enabled edges
    localparam int PER   = 14;   // conversion length, in enabled edges

    // channel, analog input, expected result
    localparam int VEC [8][3] = '{
        '{0,   0,   0},
        '{1, 255, 255},
        '{2, 300, 255},
        '{3, -20,   0},
        '{4, 128, 128},
        '{5,  77,  77},
        '{6,   1,   1},
        '{0, 254, 254}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              adc_ce = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [CH_W-1:0]   ctl_wr_chan = '0;
    logic              ctl_wr_cont = 1'b0;
    logic              data_rd = 1'b0;
    logic              cmp_in;
    logic [NPIN-1:0]   pin_in = '0;
    logic [NPIN-1:0]   port_dir = '0;
    logic [NPIN-1:0]   port_latch = '0;
    logic [CH_W-1:0]   chan_sel;
    logic              cont_mode;
    logic              coco;
    logic [RES_W-1:0]  adc_data;
    logic              busy;
    logic [RES_W-1:0]  trial_code;
    logic [NPIN-1:0]   port_rd;
    logic [NPIN-1:0]   pin_oe;
    logic [NPIN-1:0]   pin_out;

    int vin [0:7];
    int checks = 0;
    int fails = 0;
    int ce_edges = 0;
    int ce_div = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        ce_div = (ce_div == 2) ? 0 : ce_div + 1;
        adc_ce = (ce_div == 0);
    end

    always @(posedge clk) begin
        if (adc_ce) ce_edges++;
    end

    // analog model: comparator high when input at or above trial code
    always_comb cmp_in = (vin[chan_sel] >= int'(trial_code));

    adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W), .CONV_CYC(14)) dut_i (
        .clk(clk), .rst_n(rst_n), .adc_ce(adc_ce), .ctl_wr(ctl_wr),
        .ctl_wr_chan(ctl_wr_chan), .ctl_wr_cont(ctl_wr_cont), .data_rd(data_rd),
        .cmp_in(cmp_in), .pin_in(pin_in), .port_dir(port_dir), .port_latch(port_latch),
        .chan_sel(chan_sel), .cont_mode(cont_mode), .coco(coco), .adc_data(adc_data),
        .busy(busy), .trial_code(trial_code), .port_rd(port_rd), .pin_oe(pin_oe),
        .pin_out(pin_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ctl_write(input int ch, input bit cont, output int stamp);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wr_chan = CH_W'(ch);
        ctl_wr_cont = cont;
        @(negedge clk);
        ctl_wr = 1'b0;
        stamp = ce_edges;
    endtask

    task automatic read_data();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic wait_coco(output int stamp);
        stamp = -1000;
        for (int t = 0; t < 300; t++) begin
            if (coco) begin
                stamp = ce_edges;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int ws, w2, d1, d2, busy_seen;
        for (int c = 0; c < 8; c++) vin[c] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12", "coco", int'(coco), 0);
        chk("R12", "adc_data", int'(adc_data), 0);
        chk("R12", "busy", int'(busy), 0);
        chk("R12", "cont_mode", int'(cont_mode), 0);
        chk("R12", "chan_sel", int'(chan_sel), 7);

        // vector table: single conversions
        for (int k = 0; k < 8; k++) begin
            vin[VEC[k][0]] = VEC[k][1];
            ctl_write(VEC[k][0], 1'b0, ws);
            wait_coco(d1);
            chk("R1/R2", "write-to-flag edges", d1 - ws, LAT);
            chk("R3", "result", int'(adc_data), VEC[k][2]);
            chk("R5", "coco set", int'(coco), 1);
            chk("R6", "busy after single", int'(busy), 0);
            read_data();
            chk("R7", "coco after data read", int'(coco), 0);
        end

        // R6 stays idle, data holds
        repeat (45) @(negedge clk);
        chk("R6", "busy later", int'(busy), 0);
        chk("R6", "data held", int'(adc_data), 254);

        // continuous mode
        vin[1] = 50;
        ctl_write(1, 1'b1, ws);
        wait_coco(d1);
        chk("R4", "first cont result", int'(adc_data), 50);
        vin[1] = 200;
        read_data();
        chk("R7", "coco read clear in cont", int'(coco), 0);
        wait_coco(d2);
        chk("R4", "result spacing", d2 - d1, PER);
        chk("R4", "second cont result", int'(adc_data), 200);
        vin[1] = 90;
        while (ce_edges < d2 + PER) @(negedge clk);
        chk("R8", "overwrite without read", int'(adc_data), 90);
        chk("R5", "coco still set", int'(coco), 1);
        vin[1] = 33;
        ctl_write(1, 1'b0, ws);
        chk("R7", "coco after control write", int'(coco), 0);
        wait_coco(d1);
        chk("R4", "single after cont", d1 - ws, LAT);
        chk("R4", "single after cont data", int'(adc_data), 33);
        repeat (50) @(negedge clk);
        chk("R4", "continuous stopped", int'(busy), 0);
        read_data();

        // R9 abort and restart on a new channel
        vin[2] = 40;
        vin[3] = 180;
        ctl_write(2, 1'b0, ws);
        while (ce_edges < ws + 6) @(negedge clk);
        ctl_write(3, 1'b0, w2);
        wait_coco(d1);
        chk("R9", "restart latency", d1 - w2, LAT);
        chk("R9", "new channel result", int'(adc_data), 180);
        chk("R9", "chan_sel", int'(chan_sel), 3);
        read_data();

        // R10 off code
        ctl_write(7, 1'b1, ws);
        busy_seen = 0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (busy || coco) busy_seen = 1;
        end
        chk("R10", "activity when off", busy_seen, 0);
        chk("R10", "data untouched", int'(adc_data), 180);
        pin_in = 7'h55;
        port_dir = 7'h00;
        #1;
        chk("R10", "port_rd passthrough", int'(port_rd), 'h55);
        port_dir = 7'h7F;
        port_latch = 7'h2A;
        #1;
        chk("R10", "pin_oe all", int'(pin_oe), 'h7F);

        // R11 pin override with channel 2 selected
        ctl_write(2, 1'b0, ws);
        pin_in = 7'h7F;
        port_dir = 7'b0000110;
        port_latch = 7'b0000010;
        #1;
        chk("R11", "port_rd owned dir1", int'(port_rd), 'h7B);
        chk("R11", "pin_oe", int'(pin_oe), 'h02);
        chk("R11", "pin_out", int'(pin_out), 'h02);
        port_dir = 7'b0000000;
        #1;
        chk("R11", "port_rd owned dir0", int'(port_rd), 'h7B);
        chk("R11", "pin_oe none", int'(pin_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule